// File: doc/BRIEF.md
# Zeroizing Hash Message Register Bank

This block is the software-facing front end of a hash engine. Software loads a message block word by word through a simple register port that carries single-beat reads and writes, each addressed by a byte offset. Software then sets two control flags: one says the message is complete and one asks for a hash. Once both flags are set and the core is idle, the bank presents the whole block in parallel to the downstream hash core. In the same cycle it gives the core a one-cycle start pulse.

The message words hold secret data, so the bank wipes them on its own. They clear on the rising edge of the core's digest-valid signal and whenever the tamper alarm is high. Either reset source also clears them, together with the control flags. After any wipe, a read of a message word returns zero until software writes new data. The hash core and the digest readout are outside this block. The core is seen only through its data, start, busy and valid ports.

Top module: `hash_msg_bank`

## Requirements
- R1: The bank holds 16 message words of 32 bits. Word i is written and read at byte offset 4*i (0x00 to 0x3C). A read request is answered one cycle later with rdAck high and the data on rdData, and rdData is zero in every cycle without rdAck.
- R2: The control word at offset 0x40 has a start flag in bit 0 and a message-complete flag in bit 1. Writing a 1 to a bit sets that flag, and writing a 0 leaves it unchanged. When both flags are set and coreBusy is low, hashStart is high for exactly one cycle in the following cycle and both flags clear.
- R3: msgBlock carries word i on bits [32*i+31:32*i] in the cycle hashStart is high, and is all zero in every other cycle.
- R4: A synchronous reset clears all words, both flags and all outputs. A reset is a clock edge with rstN low or perRst high.
- R5: A rising edge of digestValid (high now, low in the previous cycle) zeroes all 16 words at the next clock edge.
- R6: While digestValid stays high after its rising edge, no further wipe occurs, and words written in that time keep their value.
- R7: A high tamper input zeroes all 16 words at the next clock edge, whatever the state of the core.
- R8: If a message-word write and a wipe fall in the same cycle, the word ends at zero.
- R9: A write to a message word while coreBusy is high is ignored, and wrAck still goes high one cycle after every write request.
- R10: A read of the status word at offset 0x44 returns coreBusy in bit 0 and digestValid in bit 1. A read of the control word returns the two flags in their write positions.
- R11: A read of any offset above 0x44 returns zero with a normal rdAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Global reset, active low, synchronous |
| perRst | input | 1 | Peripheral reset, active high, synchronous |
| tamper | input | 1 | Tamper alarm, wipes message words while high |
| wrReq | input | 1 | Write request, one beat |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 32 | Write data |
| wrAck | output | 1 | Write response, one cycle after the request |
| rdReq | input | 1 | Read request, one beat |
| rdAddr | input | 8 | Read byte offset |
| rdAck | output | 1 | Read response valid |
| rdData | output | 32 | Read data, zero when rdAck is low |
| coreBusy | input | 1 | Hash core is processing |
| digestValid | input | 1 | Hash core digest ready |
| hashStart | output | 1 | One-cycle start pulse to the hash core |
| msgBlock | output | 512 | Message block to the core, valid with hashStart |

## Verification
Some rules are checked by assertions on every cycle. The words must read as zero after any wipe strobe. hashStart must never last two cycles. A held-high digestValid must never raise a second wipe. No word write may pass while the core is busy. Every write must be acknowledged, and a reset must leave the flags clear. Other behaviour can only be shown by the bench scenarios, which compare the ports against a behavioural model on every clock. These include the exact data read back and the parallel block presented at the start pulse. They also include a write losing to a wipe in the same cycle, and a write surviving under a held digest-valid. Zero reads of unmapped offsets and the status bit layout are covered the same way.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam int IDX_W_MAX = 8;

  typedef struct packed {
    logic                 wrEn;
    logic [IDX_W_MAX-1:0] wrIdx;
    logic                 zeroize;
    logic                 issue;
  } hmbStrobe_t;
endpackage

// File: rtl/hmb_datapath.sv
module hmb_datapath
  import hmb_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              clrAll,
  input  logic              coreBusy,
  input  hmbStrobe_t        strobe,
  input  logic [DW-1:0]     wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              hashStart,
  output logic [DW-1:0]     rdWord,
  output logic [WORDS*DW-1:0] msgBlock
);
  logic [DW-1:0] words [WORDS];
  logic [WORDS*DW-1:0] wordsFlat;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (clrAll || strobe.zeroize) begin
        words[i] <= '0;
      end else if (strobe.wrEn && (strobe.wrIdx == IDX_W_MAX'(i))) begin
        words[i] <= wrData;
      end
    end
    assign wordsFlat[i*DW +: DW] = words[i];
  end

  assign rdWord   = words[rdIdx];
  assign msgBlock = hashStart ? wordsFlat : '0;

  // R5 R7 R8
  wipe_clears_all_chk: assert property (@(posedge clk) disable iff (clrAll)
    strobe.zeroize |=> (wordsFlat == '0));

  // R9
  no_busy_write_chk: assert property (@(posedge clk) disable iff (clrAll)
    strobe.wrEn |-> !coreBusy);
endmodule

// File: rtl/hmb_ctrl.sv
module hmb_ctrl
  import hmb_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  parameter int AW    = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             clrAll,
  input  logic             tamper,
  input  logic             digestValid,
  input  logic             coreBusy,
  input  logic             wrReq,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic             rdReq,
  input  logic [AW-1:0]    rdAddr,
  input  logic [DW-1:0]    rdWord,
  output hmbStrobe_t       strobe,
  output logic [IDX_W-1:0] rdIdx,
  output logic             hashStart,
  output logic             wrAck,
  output logic             rdAck,
  output logic [DW-1:0]    rdData
);
  localparam logic [AW-1:0] WORD_END = AW'(WORDS * 4);
  localparam logic [AW-1:0] CTRL_OFF = AW'(WORDS * 4);
  localparam logic [AW-1:0] STAT_OFF = AW'(WORDS * 4 + 4);

  logic startFlag, newFlag, dvPrev;
  logic wrHitWord, wrHitCtrl, issue, zeroize;
  logic [DW-1:0] rdMux;

  always_comb begin
    wrHitWord = wrReq && (wrAddr < WORD_END);
    wrHitCtrl = wrReq && (wrAddr == CTRL_OFF);
    issue     = startFlag && newFlag && !coreBusy;
    zeroize   = (digestValid && !dvPrev) || tamper;

    strobe.wrEn    = wrHitWord && !coreBusy;
    strobe.wrIdx   = IDX_W_MAX'(wrAddr[IDX_W+1:2]);
    strobe.zeroize = zeroize;
    strobe.issue   = issue;
  end

  assign rdIdx = rdAddr[IDX_W+1:2];

  always_comb begin
    if (rdAddr < WORD_END) begin
      rdMux = rdWord;
    end else if (rdAddr == CTRL_OFF) begin
      rdMux = {{(DW-2){1'b0}}, newFlag, startFlag};
    end else if (rdAddr == STAT_OFF) begin
      rdMux = {{(DW-2){1'b0}}, digestValid, coreBusy};
    end else begin
      rdMux = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (clrAll) begin
      startFlag <= 1'b0;
      newFlag   <= 1'b0;
      dvPrev    <= 1'b0;
      hashStart <= 1'b0;
      wrAck     <= 1'b0;
      rdAck     <= 1'b0;
      rdData    <= '0;
    end else begin
      dvPrev    <= digestValid;
      hashStart <= issue;
      wrAck     <= wrReq;
      rdAck     <= rdReq;
      rdData    <= rdReq ? rdMux : '0;
      if (issue) begin
        startFlag <= 1'b0;
        newFlag   <= 1'b0;
      end else if (wrHitCtrl) begin
        startFlag <= startFlag | wrData[0];
        newFlag   <= newFlag | wrData[1];
      end
    end
  end

  // R2
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (clrAll)
    hashStart |=> !hashStart);

  // R6
  level_no_rewipe_chk: assert property (@(posedge clk) disable iff (clrAll)
    (digestValid && $past(digestValid) && !$past(clrAll) && !tamper) |-> !strobe.zeroize);

  // R9
  write_acked_chk: assert property (@(posedge clk) disable iff (clrAll)
    wrReq |=> wrAck);

  // R4
  reset_flags_chk: assert property (@(posedge clk)
    clrAll |=> (!startFlag && !newFlag && !hashStart));
endmodule

// File: rtl/hash_msg_bank.sv
module hash_msg_bank
  import hmb_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                perRst,
  input  logic                tamper,
  input  logic                wrReq,
  input  logic [AW-1:0]       wrAddr,
  input  logic [DW-1:0]       wrData,
  output logic                wrAck,
  input  logic                rdReq,
  input  logic [AW-1:0]       rdAddr,
  output logic                rdAck,
  output logic [DW-1:0]       rdData,
  input  logic                coreBusy,
  input  logic                digestValid,
  output logic                hashStart,
  output logic [WORDS*DW-1:0] msgBlock
);
  localparam int IDX_W = $clog2(WORDS);

  logic clrAll;
  hmbStrobe_t strobe;
  logic [IDX_W-1:0] rdIdx;
  logic [DW-1:0] rdWord;

  assign clrAll = !rstN || perRst;

  hmb_ctrl #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .clrAll(clrAll), .tamper(tamper), .digestValid(digestValid),
    .coreBusy(coreBusy), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdWord(rdWord), .strobe(strobe),
    .rdIdx(rdIdx), .hashStart(hashStart), .wrAck(wrAck), .rdAck(rdAck),
    .rdData(rdData)
  );

  hmb_datapath #(.WORDS(WORDS), .DW(DW)) u_data (
    .clk(clk), .clrAll(clrAll), .coreBusy(coreBusy), .strobe(strobe),
    .wrData(wrData), .rdIdx(rdIdx), .hashStart(hashStart),
    .rdWord(rdWord), .msgBlock(msgBlock)
  );
endmodule

// File: tb/hash_msg_bank_test.sv
module hash_msg_bank_test;
  logic clk = 1'b0;
  logic rstN = 1'b0, perRst = 1'b0, tamper = 1'b0;
  logic wrReq = 1'b0, rdReq = 1'b0;
  logic [7:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic coreBusy = 1'b0, digestValid = 1'b0;
  logic wrAck, rdAck, hashStart;
  logic [31:0] rdData;
  logic [511:0] msgBlock;

  int total = 0, fails = 0;
  string curReq = "R4";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hash_msg_bank uut (
    .clk(clk), .rstN(rstN), .perRst(perRst), .tamper(tamper),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .coreBusy(coreBusy), .digestValid(digestValid), .hashStart(hashStart),
    .msgBlock(msgBlock)
  );

  // behavioural reference model
  logic [31:0] mWords [16];
  bit mStart = 0, mNew = 0, mDvPrev = 0, eStart = 0, eWrAck = 0, eRdAck = 0;
  logic [31:0] eRd = '0;

  initial for (int i = 0; i < 16; i++) mWords[i] = '0;

  function automatic logic [31:0] modelRead(logic [7:0] a);
    if (a < 8'h40) return mWords[a[5:2]];
    if (a == 8'h40) return {30'd0, mNew, mStart};
    if (a == 8'h44) return {30'd0, digestValid, coreBusy};
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rstN || perRst) begin
      for (int i = 0; i < 16; i++) mWords[i] = '0;
      mStart = 0; mNew = 0; mDvPrev = 0; eStart = 0; eWrAck = 0; eRdAck = 0; eRd = '0;
    end else begin
      bit wipe, go;
      wipe = (digestValid && !mDvPrev) || tamper;
      go = mStart && mNew && !coreBusy;
      eRdAck = rdReq;
      eRd = rdReq ? modelRead(rdAddr) : '0;
      eWrAck = wrReq;
      if (wipe) begin
        for (int i = 0; i < 16; i++) mWords[i] = '0;
      end else if (wrReq && wrAddr < 8'h40 && !coreBusy) begin
        mWords[wrAddr[5:2]] = wrData;
      end
      if (go) begin
        mStart = 0; mNew = 0;
      end else if (wrReq && wrAddr == 8'h40) begin
        mStart = mStart | wrData[0];
        mNew = mNew | wrData[1];
      end
      eStart = go;
      mDvPrev = digestValid;
    end
  end

  task automatic check(string what, logic [511:0] act, logic [511:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [511:0] eBlk;
      for (int i = 0; i < 16; i++) eBlk[i*32 +: 32] = eStart ? mWords[i] : 32'd0;
      check("wrAck", {511'd0, wrAck}, {511'd0, eWrAck});
      check("rdAck", {511'd0, rdAck}, {511'd0, eRdAck});
      check("rdData", {480'd0, rdData}, {480'd0, eRd});
      check("hashStart", {511'd0, hashStart}, {511'd0, eStart});
      check("msgBlock", msgBlock, eBlk);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wrReq = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrReq = 0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); rdReq = 1; rdAddr = a;
    @(negedge clk); rdReq = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    // R4: reset state
    curReq = "R4";
    idle(3);
    rstN = 1;
    idle(1);
    // R1: load distinct patterns and read back
    curReq = "R1";
    for (int i = 0; i < 16; i++) wr(8'(i * 4), 32'hA5A5_0000 ^ (32'h1111_1111 * i));
    for (int i = 0; i < 16; i++) rd(8'(i * 4));
    // R11: unmapped reads
    curReq = "R11";
    rd(8'h48); rd(8'h80); rd(8'hFC);
    // R2 R3 R10: flags, readback of control, start pulse with block
    curReq = "R10";
    wr(8'h40, 32'h1); rd(8'h40);
    curReq = "R2";
    wr(8'h40, 32'h0); rd(8'h40);
    curReq = "R3";
    wr(8'h40, 32'h2); idle(3); rd(8'h40);
    // R9: busy core ignores word writes
    curReq = "R9";
    coreBusy = 1;
    wr(8'h0C, 32'hDEAD_BEEF); rd(8'h0C);
    curReq = "R10";
    rd(8'h44);
    // R2: flags set while busy, start held until idle
    curReq = "R2";
    wr(8'h40, 32'h3); idle(2);
    coreBusy = 0; idle(3);
    // R5: digest-valid rising edge wipes
    curReq = "R5";
    @(negedge clk); digestValid = 1;
    idle(1);
    rd(8'h00); rd(8'h3C);
    // R6: held digest-valid, new write persists
    curReq = "R6";
    wr(8'h14, 32'h1234_5678); idle(3); rd(8'h14);
    curReq = "R10";
    rd(8'h44);
    @(negedge clk); digestValid = 0;
    // R7: tamper wipes
    curReq = "R7";
    wr(8'h20, 32'hCAFE_F00D); rd(8'h20);
    @(negedge clk); tamper = 1;
    @(negedge clk); tamper = 0;
    rd(8'h20); rd(8'h14);
    // R8: write and tamper in same cycle
    curReq = "R8";
    @(negedge clk); wrReq = 1; wrAddr = 8'h08; wrData = 32'h5555_AAAA; tamper = 1;
    @(negedge clk); wrReq = 0; tamper = 0;
    rd(8'h08);
    // R8: write and digest-valid edge in same cycle
    @(negedge clk); wrReq = 1; wrAddr = 8'h10; wrData = 32'h7777_0001; digestValid = 1;
    @(negedge clk); wrReq = 0; digestValid = 0;
    rd(8'h10);
    // R4: peripheral reset clears words and flags
    curReq = "R4";
    wr(8'h04, 32'h0BAD_CAFE); wr(8'h40, 32'h1);
    @(negedge clk); perRst = 1;
    idle(2); perRst = 0;
    rd(8'h04); rd(8'h40);
    // R3: a full start after reload shows the block once
    curReq = "R3";
    wr(8'h00, 32'h0102_0304); wr(8'h3C, 32'hFFFF_0000);
    wr(8'h40, 32'h3); idle(4);
    idle(2);
    finishRun();
  end
endmodule